// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (four by default) by repeated add and shift steps. The result builds up in one product register of `2*WIDTH+1` bits. A start pulse while the block is idle loads the register. The upper `WIDTH+1` bits are cleared, and the multiplier goes into the low `WIDTH` bits.

After the load, the block tests the register's least significant bit on each pass:
- If that bit is 1, the multiplicand is first added into the upper part of the register, and the register is then shifted right by one place.
- If that bit is 0, the register is only shifted right by one place.

A small counter tracks how many shifts have been made. Its final-value flag marks the last multiplier bit. Because of this counter, the controller needs only four states whatever `WIDTH` is. When the last shift is done, the block raises `done` for exactly one cycle and then returns to idle. At that point the low `2*WIDTH` bits of the register hold the product.

The caller holds `mcand` steady from the start pulse until `done`, because every add step reads it. A start request made while the block is busy is ignored.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst_n` is low and after its release, `product` is all zeros and `done` is 0 until a start is accepted.
- R2: `start`=1 in an idle cycle is accepted at that clock edge. After that edge, `product` bits [2W:W] are 0 and bits [W-1:0] hold `mplier`.
- R3: In a pass where `product[0]`=1, one cycle is spent on an add step. After it, `product[2W:W]` equals the old `product[2W-1:W]` plus `mcand` as a (W+1)-bit sum that includes the carry, and `product[W-1:0]` is unchanged. The shift for that bit follows in the next cycle.
- R4: Every shift step moves `product` right by one place and puts 0 into bit 2W. A pass where `product[0]`=0 spends one cycle, on the shift only.
- R5: Exactly W shifts are made per operation. `done` rises in the cycle after the W-th shift. Counting from the clock edge that accepts `start`, `done` rises after W + (number of 1 bits in `mplier`) + 1 edges.
- R6: `done` is high for exactly one cycle per operation. While it is high, `product` equals `mcand`*`mplier` (with bit 2W at 0).
- R7: `start` is ignored in every busy cycle, from the cycle after acceptance through the `done` cycle. `product` follows the same step sequence as without it.
- R8: Multiplicand 1101 times multiplier 1011 ends with `product` = 010001111.
- R9: After the `done` cycle the block is idle. `product` holds its value, `done` stays 0, and the next `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request; acted on only when idle |
| mcand | input | WIDTH | Multiplicand; held stable until done |
| mplier | input | WIDTH | Multiplier; sampled on the accepting edge |
| product | output | 2*WIDTH+1 | Product register; the result is in the low 2*WIDTH bits |
| done | output | 1 | One-cycle pulse marking a finished product |

## Verification
The `done` cycle of one operation can coincide with a new `start` request, and that request must be ignored rather than treated as a fresh load. The bench provokes this by holding `start` high from the cycle after acceptance through the `done` cycle, then dropping it. It judges the outcome in the following idle cycle: `done` must be low and `product` must still hold the finished result. A fresh request must then be accepted as normal. A cycle-by-cycle model of the register runs alongside, so a request taken by mistake during a scan or add step also shows up as a mismatch.

// File: rtl/sam_pkg.sv
package sam_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SCAN  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_DONE  = 2'd3
   } sam_state_e;

   function automatic int cnt_width(input int w);
      return (w > 2) ? $clog2(w) : 1;
   endfunction

endpackage

// File: rtl/sam_counter.sv
module sam_counter #(
   parameter int WIDTH = 4,
   parameter int CW    = sam_pkg::cnt_width(WIDTH)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic last
);
   localparam logic [CW-1:0] FINAL = CW'(WIDTH - 1);

   logic [CW-1:0] bit_idx;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sam_counter: WIDTH must be at least 2");
      end
   endgenerate

   assign last = (bit_idx == FINAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx <= '0;
      end else if (clear) begin
         bit_idx <= '0;
      end else if (step) begin
         bit_idx <= last ? '0 : bit_idx + 1'b1;
      end
   end

   p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_idx <= FINAL);

   p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (bit_idx == '0));

endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
   import sam_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic lsb,
   input  logic last,
   output logic load,
   output logic add,
   output logic shift,
   output logic done
);
   sam_state_e state, state_nx;

   always_comb begin
      state_nx = state;
      load     = 1'b0;
      add      = 1'b0;
      shift    = 1'b0;
      done     = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (start) begin
               load     = 1'b1;
               state_nx = ST_SCAN;
            end
         end
         ST_SCAN: begin
            if (lsb) begin
               add      = 1'b1;
               state_nx = ST_SHIFT;
            end else begin
               shift    = 1'b1;
               state_nx = last ? ST_DONE : ST_SCAN;
            end
         end
         ST_SHIFT: begin
            shift    = 1'b1;
            state_nx = last ? ST_DONE : ST_SCAN;
         end
         ST_DONE: begin
            done     = 1'b1;
            state_nx = ST_IDLE;
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   p_add_then_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      add |=> shift);

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !add && !shift));

   p_one_action_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load, add, shift, done}));

   p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (state == ST_IDLE));

endmodule

// File: rtl/sam_datapath.sv
module sam_datapath #(
   parameter int WIDTH = 4,
   parameter bit RIPPLE_ADD = 1'b1,
   parameter int PW = 2 * WIDTH + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             add,
   input  logic             shift,
   input  logic [WIDTH-1:0] mcand,
   input  logic [WIDTH-1:0] mplier,
   output logic [PW-1:0]    prod
);
   localparam int HI_LO = WIDTH;
   localparam int HI_HI = 2 * WIDTH - 1;

   logic [WIDTH:0] sum;

   generate
      if (RIPPLE_ADD) begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_fa
            logic a_b;
            assign a_b        = prod[HI_LO + i];
            assign sum[i]     = a_b ^ mcand[i] ^ carry[i];
            assign carry[i+1] = (a_b & mcand[i]) | (carry[i] & (a_b ^ mcand[i]));
         end
         assign sum[WIDTH] = carry[WIDTH];
      end else begin : g_behav
         assign sum = {1'b0, prod[HI_HI:HI_LO]} + {1'b0, mcand};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod <= '0;
      end else if (load) begin
         prod <= {{(WIDTH+1){1'b0}}, mplier};
      end else if (add) begin
         prod[PW-1:HI_LO] <= sum;
      end else if (shift) begin
         prod <= {1'b0, prod[PW-1:1]};
      end
   end

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (prod[PW-1:HI_LO] == '0 && prod[WIDTH-1:0] == $past(mplier)));

   p_add_keeps_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      add |=> (prod[WIDTH-1:0] == $past(prod[WIDTH-1:0])));

   p_shift_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> (prod[PW-1] == 1'b0 && prod[PW-2] == $past(prod[PW-1])));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !add && !shift) |=> $stable(prod));

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
   parameter int WIDTH      = 4,
   parameter bit RIPPLE_ADD = 1'b1,
   parameter int PW         = 2 * WIDTH + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] mcand,
   input  logic [WIDTH-1:0] mplier,
   output logic [PW-1:0]    product,
   output logic             done
);
   logic load, add, shift, last;

   generate
      if (PW != 2 * WIDTH + 1) begin : g_bad_pw
         $error("shift_add_mult: PW must equal 2*WIDTH+1");
      end
   endgenerate

   sam_ctrl u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .lsb   (product[0]),
      .last  (last),
      .load  (load),
      .add   (add),
      .shift (shift),
      .done  (done)
   );

   sam_counter #(.WIDTH(WIDTH)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (load),
      .step  (shift),
      .last  (last)
   );

   sam_datapath #(.WIDTH(WIDTH), .RIPPLE_ADD(RIPPLE_ADD), .PW(PW)) u_dp (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .add    (add),
      .shift  (shift),
      .mcand  (mcand),
      .mplier (mplier),
      .prod   (product)
   );

   p_last_shift_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && last) |=> done);

   p_done_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (product[PW-1] == 1'b0));

endmodule

// File: tb/sim_shift_add_mult.sv
`timescale 1ns/1ps
module sim_shift_add_mult;
   localparam int N  = 4;
   localparam int PW = 2 * N + 1;

   typedef struct {
      logic [PW-1:0] prod;
      int            lat;
      int            sc;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [N-1:0]  mcand = '0;
   logic [N-1:0]  mplier = '0;
   logic [PW-1:0] product;
   logic          done;

   int   vectors = 0;
   int   fails   = 0;
   int   cyc     = 0;
   exp_t sbq[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   shift_add_mult #(.WIDTH(N)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
      .mplier(mplier), .product(product), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver: pushes expected results, follows the register cycle by cycle
   task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input bit poke);
      logic [PW-1:0] mp;
      exp_t          it;
      @(negedge clk);
      mcand = a; mplier = b; start = 1'b1;
      it.prod = PW'({N'(0), a} * {N'(0), b});
      it.lat  = N + $countones(b) + 1;
      it.sc   = cyc;
      sbq.push_back(it);
      @(negedge clk);
      start = poke;   // R7: held high while busy when poke is set
      mp = '0; mp[N-1:0] = b;
      chk(product == mp, "R2 load", int'(product), int'(mp));
      for (int k = 0; k < N; k++) begin
         if (mp[0]) begin
            mp[PW-1:N] = {1'b0, mp[PW-2:N]} + {1'b0, a};
            @(negedge clk);
            chk(product == mp, "R3 add", int'(product), int'(mp));
            chk(done == 1'b0, "R6 no early done", int'(done), 0);
         end
         mp = {1'b0, mp[PW-1:1]};
         @(negedge clk);
         chk(product == mp, poke ? "R7 busy start ignored" : "R4 shift", int'(product), int'(mp));
         if (k < N - 1) chk(done == 1'b0, "R5 no early done", int'(done), 0);
      end
      // done cycle; start still high when poke set
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b0, "R9 idle after done", int'(done), 0);
      chk(product == mp, "R9 product held", int'(product), int'(mp));
   endtask

   // monitor: pops expected items when done pulses
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R6 unexpected done", 1, 0);
         end else begin
            exp_t it;
            it = sbq.pop_front();
            chk(product == it.prod, "R6 product", int'(product), int'(it.prod));
            chk((cyc - it.sc) == it.lat, "R5 latency", cyc - it.sc, it.lat);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(product == '0, "R1 reset product", int'(product), 0);
      chk(done == 1'b0, "R1 reset done", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(product == '0 && done == 1'b0, "R1 after release", int'(product), 0);

      run_op(4'b1101, 4'b1011, 1'b0);
      chk(product == 9'b010001111, "R8 worked example", int'(product), 9'h08f);
      run_op(4'd0,  4'd0,  1'b0);
      run_op(4'd15, 4'd15, 1'b0);
      run_op(4'd15, 4'd0,  1'b0);
      run_op(4'd0,  4'd15, 1'b0);
      run_op(4'd1,  4'd1,  1'b0);
      run_op(4'd8,  4'd8,  1'b0);
      run_op(4'd10, 4'd5,  1'b1);   // R7, R9: start held through done
      run_op(4'd7,  4'd9,  1'b1);
      run_op(4'd13, 4'd14, 1'b0);   // accepted right after the poked op
      for (int i = 0; i < 12; i++) begin
         run_op(4'(i * 5 + 3), 4'(i * 7 + 1), i[0]);
      end
      repeat (3) @(negedge clk);
      chk(sbq.size() == 0, "R6 all results seen", sbq.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule